// File: doc/BRIEF.md
# Phase-Aligned Clock Divider Bank with Shared Restart

The block takes one fast source clock and produces several slower clocks from it. Each output has its own programmable divide ratio. A shared sync pin restarts the dividers so that every output taking part begins its new period on the same source cycle. That makes the outputs phase-aligned with each other, and also with any other bank driven by the same pin.

There are two restart styles. In level mode the synchronized sync level mutes every participating output for as long as it stays asserted, and the outputs restart together when it is released. In qualified mode the level is not examined at all. Only the release edge arms one restart. The restart then fires on the next falling edge of a selected output, which is the qualifier, so the restart cycle is fixed relative to that clock and not to the arrival time of the pin. Outputs can opt out of sync entirely. Each output can also add a delay, counted in source cycles, before it resumes after a restart.

All configuration is static: it is changed only while reset is held.

Top module: `clkdiv_sync_bank`

## Requirements
- R1: For a full source cycle of synchronous reset, every divider is set to phase 0 with no delay pending. From the first cycle after reset all outputs run in phase and start high; the per-output delay does not apply at reset.
- R2: With the invert setting at 1, a low level on the sync pin is the asserted level. With it at 0, a high level is asserted.
- R3: In level mode, a participating output is low from 2 cycles after the pin reaches its asserted level until release. It then restarts high 2 cycles after the pin returns to idle, together with every other participating output. The mute length in cycles therefore equals the pulse length.
- R4: An output whose opt-out bit is set keeps its divided waveform through every sync event in both modes.
- R5: In qualified mode the asserted level never mutes an output. Each release edge arms exactly one restart, and no further restart happens until the next release.
- R6: In qualified mode the restart lands on the first source edge at which the qualifier output falls, counting from 4 edges after the pin release. At that edge every participating output restarts from phase 0.
- R7: After a restart, an output with delay setting D stays low for D source cycles before its first high cycle. Any value up to 63 is valid.
- R8: A divide value of D ≥ 2 gives D/2 (rounded down) high cycles followed by the remaining low cycles. A value of 0 or 1 passes the source clock straight through whenever the output is running.
- R9: The sync pin passes through two flip-flops in the source domain before it is used. This sets the 2-cycle latency in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_pin | input | 1 | Asynchronous sync request |
| cfg_div | input | N_OUT*DIV_W | Divide value per output, output i at bits [i*DIV_W +: DIV_W] |
| cfg_sync_inv | input | 1 | 1: sync asserted when the pin is low |
| cfg_qual_en | input | 1 | 1: qualified mode, 0: level mode |
| cfg_qual_sel | input | SEL_W | Index of the output used as qualifier |
| cfg_nosync | input | N_OUT | Per-output opt-out from sync |
| cfg_dly | input | N_OUT*DLY_W | Restart delay per output in source cycles, output i at bits [i*DLY_W +: DLY_W] |
| clk_out | output | N_OUT | Divided output clocks |

## Verification
The hardest case to reach is a qualified restart that lands exactly on the qualifier's falling edge. The arming and the qualifier phase are independent, so only certain combinations of pulse width and release cycle exercise the cases where the fall comes first, last or right after arming. The bench handles this by sweeping the qualifier index, its divide ratio, the pin polarity and two pulse widths. For each release it computes the landing edge arithmetically from the bench's own model of the qualifier waveform. A second pulse after each restart confirms re-arming, and the cycles between the two pulses confirm that no extra restart occurs.

// File: rtl/clkbank_pkg.sv
// Shared types for the clock divider bank.
// Assumes nothing beyond IEEE 1800-2017 packages.
package clkbank_pkg;
    typedef enum logic {
        SYNC_LEVEL     = 1'b0,
        SYNC_QUALIFIED = 1'b1
    } sync_mode_e;
endpackage

// File: rtl/clkbank_sync.sv
// Sync request front end: two-flop synchronizer, polarity select, release
// edge detection and arming of a single qualified restart.
// Assumes the polarity and mode inputs change only during reset.
module clkbank_sync
    import clkbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_pin,
    input  logic inv,
    input  logic qual_en,
    input  logic q_fall,
    output logic mute,
    output logic restart
);
    logic       s1, s2;
    logic       lvl_prev;
    logic       armed;
    logic       asserted;
    logic       released;
    sync_mode_e mode;

    // Bring the pin into the source domain, idle level out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= inv;
            s2 <= inv;
        end else begin
            s1 <= sync_pin;
            s2 <= s1;
        end
    end

    // Decode mode, asserted level and the release edge.
    always_comb begin
        mode     = qual_en ? SYNC_QUALIFIED : SYNC_LEVEL;
        asserted = s2 ^ inv;
        released = lvl_prev && !asserted;
        mute     = (mode == SYNC_LEVEL) && asserted;
        restart  = (mode == SYNC_QUALIFIED) && armed && q_fall;
    end

    // Remember the previous level and hold one pending qualified restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_prev <= 1'b0;
            armed    <= 1'b0;
        end else begin
            lvl_prev <= asserted;
            if (mode != SYNC_QUALIFIED) armed <= 1'b0;
            else if (released)          armed <= 1'b1;
            else if (restart)           armed <= 1'b0;
        end
    end

    assert_sync_stage_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (s2 == $past(s1)));
    assert_release_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_en && released) |=> armed);
    assert_single_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !released) |=> !armed);
endmodule

// File: rtl/clkbank_chan.sv
// One divider channel: phase counter, restart delay counter and output
// gating. Assumes div and dly are static outside reset. Div 0 or 1 bypasses.
module clkbank_chan #(
    parameter int DIV_W = 8,
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic [DLY_W-1:0] dly,
    input  logic             part,
    input  logic             mute,
    input  logic             restart,
    output logic             clk_o,
    output logic             fall_next
);
    logic [DIV_W-1:0] cnt;
    logic [DLY_W-1:0] dcnt;
    logic [DIV_W-1:0] half;
    logic             bypass;
    logic             reload;
    logic             running;

    // Derive the high-phase length and the restart conditions.
    always_comb begin
        half    = div >> 1;
        bypass  = (div <= {{(DIV_W-1){1'b0}}, 1'b1});
        reload  = part && (mute || restart);
        running = (dcnt == '0) && !(part && mute);
    end

    // Advance the phase counter, or wait out the restart delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            dcnt <= '0;
        end else if (reload) begin
            cnt  <= '0;
            dcnt <= dly;
        end else if (dcnt != '0) begin
            dcnt <= dcnt - 1'b1;
        end else if (bypass || cnt >= div - 1'b1) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Form the output and flag a high-to-low transition at the next edge.
    always_comb begin
        clk_o     = running && (bypass ? clk : (cnt < half));
        fall_next = (dcnt == '0) && (bypass || cnt == half - 1'b1);
    end

    assert_reload_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt == '0 && dcnt == $past(dly)));
    assert_delay_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && dcnt != '0) |=> (dcnt == $past(dcnt) - 1'b1));
    assert_nosync_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!part && dcnt == '0 && !bypass) |=> (cnt != $past(cnt)));
endmodule

// File: rtl/clkdiv_sync_bank.sv
// Top of the divider bank: one sync front end shared by N_OUT channels.
// Assumes all cfg_* inputs are changed only while rst_n is low and that
// the qualifier output has its opt-out bit set.
module clkdiv_sync_bank #(
    parameter int N_OUT = 4,
    parameter int DIV_W = 8,
    parameter int DLY_W = 6,
    parameter int SEL_W = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sync_pin,
    input  logic [N_OUT*DIV_W-1:0] cfg_div,
    input  logic                   cfg_sync_inv,
    input  logic                   cfg_qual_en,
    input  logic [SEL_W-1:0]       cfg_qual_sel,
    input  logic [N_OUT-1:0]       cfg_nosync,
    input  logic [N_OUT*DLY_W-1:0] cfg_dly,
    output logic [N_OUT-1:0]       clk_out
);
    logic [N_OUT-1:0] chan_fall;
    logic             q_fall;
    logic             mute;
    logic             restart;

    // Pick the qualifier's falling-edge flag.
    always_comb q_fall = chan_fall[cfg_qual_sel];

    clkbank_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_pin (sync_pin),
        .inv      (cfg_sync_inv),
        .qual_en  (cfg_qual_en),
        .q_fall   (q_fall),
        .mute     (mute),
        .restart  (restart)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_chan
        clkbank_chan #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .div       (cfg_div[i*DIV_W +: DIV_W]),
            .dly       (cfg_dly[i*DLY_W +: DLY_W]),
            .part      (!cfg_nosync[i]),
            .mute      (mute),
            .restart   (restart),
            .clk_o     (clk_out[i]),
            .fall_next (chan_fall[i])
        );
    end

    assert_no_mute_on_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> !mute);
endmodule

// File: tb/sim_clkdiv_sync_bank.sv
// Sweep bench for the divider bank; a cycle-level model of each output.
module sim_clkdiv_sync_bank;
    localparam int N   = 4;
    localparam int DW  = 8;
    localparam int LW  = 6;
    localparam int INF = 32'h3fffffff;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sync_pin = 1'b0;
    logic            inv = 1'b0;
    logic            qual = 1'b0;
    logic [1:0]      qsel = '0;
    logic [N-1:0]    nosync = '0;
    logic [N*DW-1:0] divv = '0;
    logic [N*LW-1:0] dlyv = '0;
    logic [N-1:0]    clk_out;

    int div_a[N];
    int dly_a[N];
    int ref_e[N];
    int effd[N];
    int edge_cnt = 0;
    int mute_from = INF;
    int mute_to = INF;
    int pend_at = -1;
    int checks = 0;
    int errors = 0;

    clkdiv_sync_bank #(.N_OUT(N), .DIV_W(DW), .DLY_W(LW)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_pin     (sync_pin),
        .cfg_div      (divv),
        .cfg_sync_inv (inv),
        .cfg_qual_en  (qual),
        .cfg_qual_sel (qsel),
        .cfg_nosync   (nosync),
        .cfg_dly      (dlyv),
        .clk_out      (clk_out)
    );

    always #10 clk = ~clk;
    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    always @(posedge clk) begin
        if (edge_cnt > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired at edge %0d", edge_cnt);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic expv(int i, int e);
        int k;
        int d;
        if (!qual && !nosync[i] && e >= mute_from && e <= mute_to) return 1'b0;
        k = e - ref_e[i];
        d = effd[i];
        if (k < d) return 1'b0;
        if (div_a[i] <= 1) return 1'b1;
        return (((k - d) % div_a[i]) < (div_a[i] / 2));
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < N; i++) begin
            divv[i*DW +: DW] = DW'(div_a[i]);
            dlyv[i*LW +: LW] = LW'(dly_a[i]);
        end
        sync_pin = inv;
        repeat (3) @(posedge clk);
        #12;
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) begin
            ref_e[i] = edge_cnt;
            effd[i]  = 0;
        end
        mute_from = INF;
        mute_to   = INF;
        pend_at   = -1;
    endtask

    task automatic step(int n, string tag);
        for (int c = 0; c < n; c++) begin
            @(posedge clk);
            #5;
            if (edge_cnt == pend_at) begin
                for (int i = 0; i < N; i++) begin
                    if (!nosync[i]) begin
                        ref_e[i] = pend_at;
                        effd[i]  = dly_a[i];
                    end
                end
            end
            for (int i = 0; i < N; i++) begin
                logic ex;
                string t;
                ex = expv(i, edge_cnt);
                t  = nosync[i] ? "R4" : ((div_a[i] <= 1) ? "R8" : tag);
                checks = checks + 1;
                if (clk_out[i] !== ex) begin
                    errors = errors + 1;
                    $display("FAIL %s ch%0d edge %0d: got %b expected %b",
                             t, i, edge_cnt, clk_out[i], ex);
                end
            end
            #7;
        end
    endtask

    task automatic pulse_level(int w, int post, string tag);
        int c;
        int d;
        c = edge_cnt;
        sync_pin  = ~inv;
        mute_from = c + 2;
        mute_to   = INF;
        step(w, tag);
        d = edge_cnt;
        sync_pin = inv;
        mute_to  = d + 1;
        pend_at  = d + 2;
        step(post, tag);
    endtask

    task automatic pulse_qual(int w, string tag);
        int d;
        int e;
        sync_pin = ~inv;
        step(w, tag);
        d = edge_cnt;
        sync_pin = inv;
        e = d + 4;
        if (div_a[qsel] > 1) begin
            while (!(expv(int'(qsel), e - 1) == 1'b1 && expv(int'(qsel), e) == 1'b0))
                e = e + 1;
        end
        pend_at = e;
        step(30, tag);
    endtask

    initial begin
        // R1: reset alignment, delays not applied at reset
        div_a = '{2, 3, 4, 5};
        dly_a = '{2, 2, 2, 2};
        nosync = 4'b0000;
        qual = 1'b0;
        inv = 1'b0;
        do_reset();
        step(30, "R1");

        // R3 R9 and R2: level mode sweep over divide, polarity and width
        for (int pv = 0; pv < 2; pv++) begin
            for (int d0 = 1; d0 <= 6; d0++) begin
                for (int wi = 0; wi < 2; wi++) begin
                    div_a  = '{d0, 3, 4, 5};
                    dly_a  = '{0, 0, 3, 1};
                    nosync = 4'b1000;
                    qual   = 1'b0;
                    inv    = pv[0];
                    do_reset();
                    step(4, "R1");
                    pulse_level(wi ? 4 : 1, 25, pv ? "R2 R3 R9" : "R3 R9");
                end
            end
        end

        // R5 R6: qualified mode, each output as qualifier
        for (int q = 0; q < N; q++) begin
            for (int pv = 0; pv < 2; pv++) begin
                for (int wi = 0; wi < 2; wi++) begin
                    div_a  = '{3, 4, 2, 1};
                    dly_a  = '{1, 0, 2, 0};
                    nosync = 4'(1 << q);
                    qual   = 1'b1;
                    qsel   = 2'(q);
                    inv    = pv[0];
                    do_reset();
                    step(5, "R5 R6");
                    pulse_qual(wi ? 7 : 2, "R5 R6");
                    pulse_qual(3, "R5 R6");
                end
            end
        end

        // R7: long restart delay, including the largest value 63
        div_a  = '{4, 6, 2, 3};
        dly_a  = '{0, 63, 5, 0};
        nosync = 4'b0000;
        qual   = 1'b0;
        inv    = 1'b1;
        do_reset();
        step(3, "R7");
        pulse_level(2, 80, "R7");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule